// File: doc/BRIEF.md
# Serial Port with Hardware Address-Frame Filtering

This block is a full-duplex asynchronous serial port. A frame carries either eight or nine data bits. Writing a byte to the data port starts a transmission. In nine-bit mode the extra bit is taken from a control input. The receiver watches the line, samples each bit at its midpoint, and builds the byte plus one extra bit. In eight-bit mode that extra bit is the stop bit, and in nine-bit mode it is the ninth data bit. The receiver then decides whether to hand the frame over.

The receiver has two stages. A frame can shift in while software has not yet read the previous byte. A finished frame is copied into the read latch only if the receive-done flag is clear and the filter allows it. With filtering on, the latched extra bit must be 1. In nine-bit mode this passes address frames and hides data frames. In eight-bit mode it drops frames with a bad stop bit. The transmit-done and receive-done flags are set only by hardware and cleared only by software. The interrupt request is their OR, gated by an enable. The bit rate comes from an external tick at sixteen times the bit rate.

Top module: `mpuart`

## Requirements
- R1: The transmit line idles high. After a write it sends a start bit (0), eight data bits LSB first, then in nine-bit mode (`cfg_nine`=1) the value of `cfg_tx_bit9`, then a stop bit (1). Each bit lasts 16 ticks of `baud_tick`.
- R2: `tx_done` rises at the start of the stop bit. It then stays 1 until `clr_tx_done` is pulsed.
- R3: When a frame is accepted, `rd_data` shows its eight data bits and `rx_done` becomes 1. `rx_bit9` shows the stop bit in eight-bit mode, or the ninth data bit in nine-bit mode, where the stop level is ignored.
- R4: With `cfg_filter`=1, a frame whose extra bit (as defined in R3) is 0 leaves `rd_data`, `rx_bit9` and `rx_done` unchanged. With `cfg_filter`=0 the extra bit does not affect acceptance.
- R5: A frame that completes while `rx_done` is 1 is dropped, and the earlier byte and extra bit stay readable.
- R6: `rx_done` stays 1 until `clr_rx_done` is pulsed.
- R7: While `cfg_rx_en` is 0, no frame is received.
- R8: A low pulse on `rxd` that is high again at the midpoint of the start bit is not taken as a frame.
- R9: `irq` equals `irq_en` AND (`tx_done` OR `rx_done`).
- R10: After reset, `txd`=1 and `tx_done`, `rx_done`, `rx_bit9`, `irq` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Receive latch |
| cfg_nine | input | 1 | 1 = nine-bit frames, 0 = eight-bit frames |
| cfg_filter | input | 1 | Enables the extra-bit acceptance filter |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_tx_bit9 | input | 1 | Ninth bit sent in nine-bit mode |
| irq_en | input | 1 | Interrupt enable |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_done | input | 1 | Clears the receive-done flag |
| tx_done | output | 1 | Sticky transmit-done flag |
| rx_done | output | 1 | Sticky receive-done flag |
| rx_bit9 | output | 1 | Latched extra bit of the accepted frame |
| irq | output | 1 | Interrupt request |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
A wrong receive state shows at the ports within one frame. If the sample counter is off, every later byte comes out shifted. If the filter or overrun decision is wrong, `rx_done`, `rd_data` or `rx_bit9` show it at the stop-bit midpoint. A slip in the transmit bit counter shows as a misplaced bit level or a `tx_done` edge one bit early or late, and sampling `txd` at each bit midpoint catches it before the frame ends. Glitches and disabled reception are checked by confirming that the latch and flags have not changed before the next real frame arrives.

// File: rtl/mpuart_pkg.sv
// Shared types and helpers for the serial port.
// Assumes: one clock domain; the caller supplies the oversampling tick.
package mpuart_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

    // Acceptance rule: with filtering on, the latched extra bit must be 1.
    function automatic logic frame_passes(input logic filter_on, input logic extra_bit);
        return !filter_on || extra_bit;
    endfunction
endpackage

// File: rtl/mpuart_tx.sv
// Transmit serializer: start bit, DW data bits LSB first, optional ninth bit, stop bit.
// Assumes: tick is a one-cycle pulse at OVS times the bit rate; writes while busy are ignored.
module mpuart_tx #(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  logic          nine,
    input  logic          bit9,
    output logic          txd,
    output logic          busy,
    output logic          stop_begin
);
    localparam int FW = DW + 3;
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(FW + 1);

    logic [FW-1:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] last_q;
    logic          busy_q;

    // Load a frame on write, then shift one bit every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q       <= '1;
            cnt_q      <= '0;
            idx_q      <= '0;
            last_q     <= '0;
            busy_q     <= 1'b0;
            stop_begin <= 1'b0;
        end else begin
            stop_begin <= 1'b0;
            if (!busy_q && start) begin
                busy_q <= 1'b1;
                sh_q   <= {1'b1, (nine ? bit9 : 1'b1), data, 1'b0};
                cnt_q  <= '0;
                idx_q  <= '0;
                last_q <= nine ? IW'(DW + 2) : IW'(DW + 1);
            end else if (busy_q && tick) begin
                if (cnt_q == CW'(OVS - 1)) begin
                    cnt_q <= '0;
                    if (idx_q == last_q) begin
                        busy_q <= 1'b0;
                        sh_q   <= '1;
                    end else begin
                        sh_q  <= {1'b1, sh_q[FW-1:1]};
                        idx_q <= idx_q + 1'b1;
                        if (IW'(idx_q + 1'b1) == last_q) stop_begin <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign txd  = sh_q[0];
    assign busy = busy_q;

    // Line must rest high whenever no frame is in flight.
    assert_tx_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> txd);
endmodule

// File: rtl/mpuart_rx.sv
// Receive deserializer with a mid-bit sample and start-bit rejection.
// Assumes: tick at OVS times the bit rate; rxd is asynchronous and is synchronized here.
// Reports each finished frame with a one-cycle end pulse; acceptance is decided by the parent.
module mpuart_rx #(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          en,
    input  logic          nine,
    output logic          frame_end,
    output logic [DW-1:0] frame_data,
    output logic          frame_extra
);
    import mpuart_pkg::*;

    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;
    localparam int IW   = $clog2(DW + 2);

    logic [1:0]    sync_q;
    rx_state_t     st_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] data_q;
    logic          extra_q;
    logic          nine_q;
    logic          end_q;
    logic          mid;
    logic          line;

    assign line = sync_q[1];
    assign mid  = (cnt_q == CW'(HALF - 1));

    // Two-flop synchronizer for the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Frame state machine: detect start, verify it at mid-bit, shift bits, report end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
            extra_q <= 1'b0;
            nine_q  <= 1'b0;
            end_q   <= 1'b0;
        end else begin
            end_q <= 1'b0;
            if (tick) begin
                if (st_q != RX_IDLE) cnt_q <= (cnt_q == CW'(OVS - 1)) ? '0 : cnt_q + 1'b1;
                unique case (st_q)
                    RX_IDLE: if (en && !line) begin
                        st_q   <= RX_START;
                        cnt_q  <= '0;
                        idx_q  <= '0;
                        nine_q <= nine;
                    end
                    RX_START: if (mid) st_q <= line ? RX_IDLE : RX_BITS;
                    RX_BITS: if (mid) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q < IW'(DW)) begin
                            data_q <= {line, data_q[DW-1:1]};
                        end else if (idx_q == IW'(DW)) begin
                            extra_q <= line;
                            if (!nine_q) begin
                                end_q <= 1'b1;
                                st_q  <= RX_IDLE;
                            end
                        end else begin
                            end_q <= 1'b1;
                            st_q  <= RX_IDLE;
                        end
                    end
                    default: st_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign frame_end   = end_q;
    assign frame_data  = data_q;
    assign frame_extra = extra_q;

    // A frame can only finish from the bit-shifting state, never straight from idle detection.
    assert_end_after_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        end_q |-> $past(st_q) == RX_BITS);
endmodule

// File: rtl/mpuart.sv
// Serial port top: transmitter, receiver, receive latch, sticky flags and interrupt.
// Assumes: software clears flags with one-cycle pulses; a hardware set wins over a clear
// arriving in the same cycle.
module mpuart #(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          cfg_nine,
    input  logic          cfg_filter,
    input  logic          cfg_rx_en,
    input  logic          cfg_tx_bit9,
    input  logic          irq_en,
    input  logic          clr_tx_done,
    input  logic          clr_rx_done,
    output logic          tx_done,
    output logic          rx_done,
    output logic          rx_bit9,
    output logic          irq,
    input  logic          rxd,
    output logic          txd
);
    import mpuart_pkg::*;

    logic          tx_busy;
    logic          tx_stop;
    logic          rx_end;
    logic [DW-1:0] rx_data;
    logic          rx_extra;
    logic          accept;
    logic [DW-1:0] latch_q;
    logic          b9_q;
    logic          txf_q;
    logic          rxf_q;

    mpuart_tx #(.OVS(OVS), .DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(wr_en), .data(wr_data),
        .nine(cfg_nine), .bit9(cfg_tx_bit9), .txd(txd), .busy(tx_busy), .stop_begin(tx_stop)
    );

    mpuart_rx #(.OVS(OVS), .DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd), .en(cfg_rx_en),
        .nine(cfg_nine), .frame_end(rx_end), .frame_data(rx_data), .frame_extra(rx_extra)
    );

    assign accept = rx_end && !rxf_q && frame_passes(cfg_filter, rx_extra);

    // Receive latch: updated only by an accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            b9_q    <= 1'b0;
        end else if (accept) begin
            latch_q <= rx_data;
            b9_q    <= rx_extra;
        end
    end

    // Sticky flags: hardware sets, software clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txf_q <= 1'b0;
            rxf_q <= 1'b0;
        end else begin
            if (tx_stop)          txf_q <= 1'b1;
            else if (clr_tx_done) txf_q <= 1'b0;
            if (accept)           rxf_q <= 1'b1;
            else if (clr_rx_done) rxf_q <= 1'b0;
        end
    end

    assign rd_data = latch_q;
    assign rx_bit9 = b9_q;
    assign tx_done = txf_q;
    assign rx_done = rxf_q;
    assign irq     = irq_en && (txf_q || rxf_q);

    assert_tx_done_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done && !clr_tx_done |=> tx_done);
    assert_tx_done_in_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> txd && tx_busy);
    assert_rx_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !clr_rx_done |=> rx_done);
    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> $stable(rd_data) && $stable(rx_bit9));
    assert_filter_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) && $past(cfg_filter) |-> rx_bit9);
endmodule

// File: tb/mpuart_bench.sv
// Self-checking bench: random frames through a reference model plus directed corner cases.
module mpuart_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       cfg_nine = 1'b0, cfg_filter = 1'b0, cfg_rx_en = 1'b1, cfg_tx_bit9 = 1'b0;
    logic       irq_en = 1'b1, clr_tx_done = 1'b0, clr_rx_done = 1'b0;
    logic       tx_done, rx_done, rx_bit9, irq, txd;
    logic       rxd = 1'b1;
    logic [1:0] tdiv = '0;

    int nvec = 0;
    int nfail = 0;
    logic [7:0] exp_data = '0;
    logic       exp_b9 = 1'b0;
    logic       exp_done = 1'b0;

    localparam int BITCLK = 64;

    mpuart u_mpuart (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cfg_nine(cfg_nine), .cfg_filter(cfg_filter), .cfg_rx_en(cfg_rx_en),
        .cfg_tx_bit9(cfg_tx_bit9), .irq_en(irq_en), .clr_tx_done(clr_tx_done),
        .clr_rx_done(clr_rx_done), .tx_done(tx_done), .rx_done(rx_done), .rx_bit9(rx_bit9),
        .irq(irq), .rxd(rxd), .txd(txd)
    );

    always #5 clk = ~clk;

    // Tick every fourth clock: 16 ticks make one 64-clock bit.
    always @(posedge clk) begin
        tdiv      <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd3);
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic model_accept(input logic en, input logic done, input logic filt,
                                          input logic extra);
        return en && !done && (!filt || extra);
    endfunction

    task automatic clr_rx();
        @(negedge clk) clr_rx_done = 1'b1;
        @(negedge clk) clr_rx_done = 1'b0;
        exp_done = 1'b0;
    endtask

    task automatic clr_tx();
        @(negedge clk) clr_tx_done = 1'b1;
        @(negedge clk) clr_tx_done = 1'b0;
    endtask

    // Drive one frame on rxd; a bad stop bit is held low only briefly.
    task automatic send_rx(input logic [7:0] d, input logic b9, input logic stopb);
        logic extra;
        @(negedge clk) rxd = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BITCLK) @(negedge clk);
        end
        if (cfg_nine) begin
            rxd = b9;
            repeat (BITCLK) @(negedge clk);
        end
        rxd = stopb;
        repeat (stopb ? BITCLK : 40) @(negedge clk);
        rxd = 1'b1;
        repeat (stopb ? BITCLK : 88) @(negedge clk);
        extra = cfg_nine ? b9 : stopb;
        if (model_accept(cfg_rx_en, exp_done, cfg_filter, extra)) begin
            exp_data = d;
            exp_b9   = extra;
            exp_done = 1'b1;
        end
    endtask

    task automatic check_rx(input string req);
        check({8'h0, rd_data}, {8'h0, exp_data}, req);
        check({15'h0, rx_bit9}, {15'h0, exp_b9}, req);
        check({15'h0, rx_done}, {15'h0, exp_done}, req);
        check({15'h0, irq}, {15'h0, irq_en & (tx_done | exp_done)}, "R9");
    endtask

    // Write a byte and check every bit at its midpoint, plus the done-flag edge (R1, R2).
    task automatic tx_frame(input logic [7:0] d, input logic nine, input logic b9);
        int guard;
        logic [10:0] bits;
        int nb;
        cfg_nine = nine;
        cfg_tx_bit9 = b9;
        clr_tx();
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
        guard = 0;
        while (txd !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
        bits = nine ? {1'b1, b9, d, 1'b0} : {1'b1, 1'b1, d, 1'b0};
        nb = nine ? 11 : 10;
        repeat (BITCLK / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            check({15'h0, txd}, {15'h0, bits[i]}, "R1");
            if (i == nb - 2) check({15'h0, tx_done}, 16'h0, "R2");
            if (i == nb - 1) check({15'h0, tx_done}, 16'h1, "R2");
            if (i < nb - 1) repeat (BITCLK) @(negedge clk);
        end
        repeat (BITCLK) @(negedge clk);
        check({15'h0, txd}, 16'h1, "R1");
        check({15'h0, irq}, {15'h0, irq_en}, "R9");
        repeat (5) @(negedge clk);
        check({15'h0, tx_done}, 16'h1, "R2");
        clr_tx();
        check({15'h0, tx_done}, 16'h0, "R2");
    endtask

    initial begin
        #(1900000);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (5) @(negedge clk);
        // R10: reset state
        check({15'h0, txd}, 16'h1, "R10");
        check({15'h0, tx_done}, 16'h0, "R10");
        check({15'h0, rx_done}, 16'h0, "R10");
        check({15'h0, irq}, 16'h0, "R10");
        check({8'h0, rd_data}, 16'h0, "R10");
        check({15'h0, rx_bit9}, 16'h0, "R10");
        @(negedge clk) rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1/R2 directed and random transmit frames
        tx_frame(8'hA5, 1'b0, 1'b0);
        tx_frame(8'h3C, 1'b1, 1'b1);
        tx_frame(8'hFF, 1'b1, 1'b0);
        for (int k = 0; k < 5; k++)
            tx_frame(8'($urandom), 1'($urandom), 1'($urandom));

        // R3: plain eight-bit receive, filter off
        cfg_nine = 1'b0; cfg_filter = 1'b0;
        send_rx(8'h5A, 1'b0, 1'b1);
        check_rx("R3");
        // R5: second frame while flag set is dropped
        send_rx(8'hC3, 1'b0, 1'b1);
        check_rx("R5");
        check({8'h0, rd_data}, 16'h005A, "R5");
        // R6: flag persists, then clears on request
        repeat (300) @(negedge clk);
        check({15'h0, rx_done}, 16'h1, "R6");
        clr_rx();
        check({15'h0, rx_done}, 16'h0, "R6");
        // R4: eight-bit bad stop with filter on is hidden
        cfg_filter = 1'b1;
        send_rx(8'h11, 1'b0, 1'b0);
        check_rx("R4");
        check({15'h0, rx_done}, 16'h0, "R4");
        // R4: nine-bit data frame hidden, address frame passes
        cfg_nine = 1'b1;
        send_rx(8'h22, 1'b0, 1'b1);
        check_rx("R4");
        send_rx(8'h47, 1'b1, 1'b0);
        check_rx("R4");
        check({15'h0, rx_bit9}, 16'h1, "R3");
        clr_rx();
        // R7: disabled receiver ignores a frame
        cfg_rx_en = 1'b0; cfg_filter = 1'b0;
        send_rx(8'h99, 1'b1, 1'b1);
        check_rx("R7");
        check({15'h0, rx_done}, 16'h0, "R7");
        cfg_rx_en = 1'b1;
        // R8: short low glitch is rejected
        @(negedge clk) rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        check_rx("R8");
        check({15'h0, rx_done}, 16'h0, "R8");

        // Random frames against the reference model (R3, R4, R5, R9)
        for (int k = 0; k < 40; k++) begin
            cfg_nine   = 1'($urandom);
            cfg_filter = 1'($urandom);
            irq_en     = 1'($urandom);
            if (($urandom % 3) != 0) clr_rx();
            send_rx(8'($urandom), 1'($urandom), (($urandom % 4) != 0));
            check_rx("R4");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule